// File: doc/BRIEF.md
# Relative Branch Decision Unit

This block resolves one branch for a small 8-bit controller core. The caller presents the address of the branch, its length in bytes, a class code, the carry flag, the accumulator, two compare operands, a loop counter value and a signed 8-bit displacement, then pulses `start_i`. One clock later the block raises `done_o` for one cycle. It then presents the next program counter, whether the branch was taken, the carry value to write back, the loop counter value to write back, and how many machine cycles the instruction costs.

A relative branch lands at the address of the first byte after the branch, offset by the sign-extended displacement. The reach is therefore -128 to +127 bytes from that address. All address arithmetic wraps within the 16-bit space. The results stay in their registers until the next start, so a slow pipeline stage can read them at any later cycle.

Top module: `rel_branch_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `taken_o`, `carry_o`, `next_pc_o`, `loop_o` and `cycles_o` all read zero until the first start.
- R2: `done_o` is high exactly in the cycle after a cycle in which `start_i` was high. Without a start, every result output holds its value.
- R3: For a taken branch, `next_pc_o` = (`pc_i` + `len_i` + sign-extended `disp_i`) mod 2^16. Displacement bytes 0x80..0xFF are negative; for example 0xFB means -5.
- R4: For a branch not taken, `next_pc_o` = (`pc_i` + `len_i`) mod 2^16.
- R5: Class code 0 (short jump) is always taken, whatever the flags and operands.
- R6: Class code 1 (jump on zero) is taken exactly when `acc_i` is 0x00.
- R7: Class code 2 (jump on no carry) is taken exactly when `carry_i` is 0.
- R8: Class code 3 (compare and jump if unequal) is taken exactly when `op_a_i` differs from `op_b_i`. For this class `carry_o` is 1 when `op_a_i` < `op_b_i` as unsigned numbers and 0 otherwise. For every other class `carry_o` equals `carry_i`.
- R9: Class code 4 (decrement and jump if nonzero) gives `loop_o` = (`loop_i` - 1) mod 256 and is taken exactly when that result is nonzero. An input of 0x00 therefore yields 0xFF and is taken. For every other class `loop_o` equals `loop_i`.
- R10: `cycles_o` is 2 for a taken branch and 1 for a branch not taken.
- R11: Class codes 5, 6 and 7 are reserved. They are never taken, and they leave the carry and loop values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Resolve the branch presented this cycle |
| pc_i | input | 16 | Address of the branch's first byte |
| len_i | input | 2 | Branch length in bytes |
| cls_i | input | 3 | Branch class code |
| carry_i | input | 1 | Current carry flag |
| acc_i | input | 8 | Accumulator value |
| op_a_i | input | 8 | First compare operand |
| op_b_i | input | 8 | Second compare operand |
| loop_i | input | 8 | Loop counter value before the decrement |
| disp_i | input | 8 | Signed displacement |
| done_o | output | 1 | Result valid pulse |
| next_pc_o | output | 16 | Resolved next address |
| taken_o | output | 1 | Branch taken |
| carry_o | output | 1 | Carry value to write back |
| loop_o | output | 8 | Loop counter value to write back |
| cycles_o | output | 2 | Machine cycles spent |

## Verification
The assertions assume that `start_i` is held low during reset. They also assume that every input is steady for the whole cycle in which `start_i` is high, since each property compares a result with the past value of an input. The bench drives all inputs on the falling edge, raises `start_i` for exactly one cycle per operation, and keeps it low while reset is active. Its sweeps cover every displacement byte at addresses close to both ends of the address space, every loop value, a grid of operand pairs, and all eight class codes, including the reserved ones.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [2:0] {
    CLS_SJMP = 3'd0,
    CLS_JZ   = 3'd1,
    CLS_JNC  = 3'd2,
    CLS_CJNE = 3'd3,
    CLS_DJNZ = 3'd4
  } br_cls_e;

  typedef struct packed {
    logic       taken;
    logic       carry;
    logic [7:0] loop;
  } br_dec_t;
endpackage

// File: rtl/rbd_target.sv
module rbd_target #(
  parameter int PC_W   = 16,
  parameter int LEN_W  = 2,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [PC_W-1:0]   seq_pc_o,
  output logic [PC_W-1:0]   jmp_pc_o
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  // offset applies to the address following the branch
  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign seq_pc_o = pc_i + PC_W'(len_i);
  assign jmp_pc_o = seq_pc_o + disp_ext;
endmodule

// File: rtl/rbd_cond.sv
module rbd_cond
  import rbd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        cls_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [DATA_W-1:0] loop_i,
  output logic              taken_o,
  output logic              carry_o,
  output logic [DATA_W-1:0] loop_o
);
  logic [DATA_W-1:0] dec;
  logic              lt;

  assign dec = loop_i - DATA_W'(1);
  assign lt  = op_a_i < op_b_i;

  always_comb begin
    taken_o = 1'b0;
    carry_o = carry_i;
    loop_o  = loop_i;
    case (cls_i)
      CLS_SJMP: taken_o = 1'b1;
      CLS_JZ:   taken_o = (acc_i == '0);
      CLS_JNC:  taken_o = ~carry_i;
      CLS_CJNE: begin
        taken_o = (op_a_i != op_b_i);
        carry_o = lt;
      end
      CLS_DJNZ: begin
        loop_o  = dec;
        taken_o = (dec != '0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit #(
  parameter int PC_W   = 16,
  parameter int LEN_W  = 2,
  parameter int DISP_W = 8,
  parameter int DATA_W = 8,
  parameter int CYC_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        cls_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [DATA_W-1:0] loop_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              done_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              carry_o,
  output logic [DATA_W-1:0] loop_o,
  output logic [CYC_W-1:0]  cycles_o
);
  localparam logic [CYC_W-1:0] CYC_TAKEN = CYC_W'(2);
  localparam logic [CYC_W-1:0] CYC_FALL  = CYC_W'(1);

  logic [PC_W-1:0]   seq_pc, jmp_pc;
  logic              tk, cy;
  logic [DATA_W-1:0] lp;

  rbd_target #(.PC_W(PC_W), .LEN_W(LEN_W), .DISP_W(DISP_W)) u_target (
    .pc_i     (pc_i),
    .len_i    (len_i),
    .disp_i   (disp_i),
    .seq_pc_o (seq_pc),
    .jmp_pc_o (jmp_pc)
  );

  rbd_cond #(.DATA_W(DATA_W)) u_cond (
    .cls_i   (cls_i),
    .carry_i (carry_i),
    .acc_i   (acc_i),
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .loop_i  (loop_i),
    .taken_o (tk),
    .carry_o (cy),
    .loop_o  (lp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      next_pc_o <= '0;
      taken_o   <= 1'b0;
      carry_o   <= 1'b0;
      loop_o    <= '0;
      cycles_o  <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        next_pc_o <= tk ? jmp_pc : seq_pc;
        taken_o   <= tk;
        carry_o   <= cy;
        loop_o    <= lp;
        cycles_o  <= tk ? CYC_TAKEN : CYC_FALL;
      end
    end
  end
endmodule

// File: rtl/rel_branch_unit_chk.sv
module rel_branch_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [15:0] pc_i,
  input logic [1:0]  len_i,
  input logic [2:0]  cls_i,
  input logic        carry_i,
  input logic [7:0]  acc_i,
  input logic [7:0]  op_a_i,
  input logic [7:0]  op_b_i,
  input logic [7:0]  loop_i,
  input logic [7:0]  disp_i,
  input logic        done_o,
  input logic [15:0] next_pc_o,
  input logic        taken_o,
  input logic        carry_o,
  input logic [7:0]  loop_o,
  input logic [1:0]  cycles_o
);
  assert_done_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_no_spurious_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  assert_hold_pc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(next_pc_o) && $stable(taken_o) && $stable(loop_o));
  assert_fall_pc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> taken_o || next_pc_o == $past(pc_i) + 16'($past(len_i)));
  assert_jump_pc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !taken_o ||
      next_pc_o == $past(pc_i) + 16'($past(len_i)) + {{8{$past(disp_i[7])}}, $past(disp_i)});
  assert_sjmp_taken_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cls_i == 3'd0 |=> taken_o);
  assert_jnc_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cls_i == 3'd2 && carry_i |=> !taken_o);
  assert_cjne_equal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cls_i == 3'd3 && op_a_i == op_b_i |=> !taken_o && !carry_o);
  assert_djnz_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cls_i == 3'd4 && loop_i == 8'd1 |=> !taken_o && loop_o == 8'd0);
  assert_reserved_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cls_i > 3'd4 |=> !taken_o && carry_o == $past(carry_i) && loop_o == $past(loop_i));
  always_comb begin
    if (rst_ni && done_o)
      assert_cycles_R10: assert (cycles_o == (taken_o ? 2'd2 : 2'd1));
  end
endmodule

bind rel_branch_unit rel_branch_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pc_i(pc_i), .len_i(len_i),
  .cls_i(cls_i), .carry_i(carry_i), .acc_i(acc_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
  .loop_i(loop_i), .disp_i(disp_i), .done_o(done_o), .next_pc_o(next_pc_o),
  .taken_o(taken_o), .carry_o(carry_o), .loop_o(loop_o), .cycles_o(cycles_o)
);

// File: tb/rel_branch_unit_bench.sv
module rel_branch_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [1:0]  len_i = '0;
  logic [2:0]  cls_i = '0;
  logic        carry_i = 1'b0;
  logic [7:0]  acc_i = '0, op_a_i = '0, op_b_i = '0, loop_i = '0, disp_i = '0;
  logic        done_o, taken_o, carry_o;
  logic [15:0] next_pc_o;
  logic [7:0]  loop_o;
  logic [1:0]  cycles_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  rel_branch_unit u_rel_branch_unit (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] c, input logic [15:0] pc, input logic [1:0] ln,
                        input logic cy, input logic [7:0] acc, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] lp, input logic [7:0] d,
                        input string req);
    logic        e_tk, e_cy;
    logic [7:0]  e_lp;
    logic [15:0] e_pc;
    e_cy = cy;
    e_lp = lp;
    case (c)
      3'd0: e_tk = 1'b1;
      3'd1: e_tk = (acc == 8'd0);
      3'd2: e_tk = !cy;
      3'd3: begin e_tk = (a != b); e_cy = (a < b); end
      3'd4: begin e_lp = lp - 8'd1; e_tk = (e_lp != 8'd0); end
      default: e_tk = 1'b0;
    endcase
    e_pc = pc + {14'd0, ln};
    if (e_tk) e_pc = e_pc + {{8{d[7]}}, d};
    @(negedge clk_i);
    start_i = 1'b1; cls_i = c; pc_i = pc; len_i = ln; carry_i = cy;
    acc_i = acc; op_a_i = a; op_b_i = b; loop_i = lp; disp_i = d;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b1, {req, " R2 done"}, done_o, 1);
    chk(taken_o == e_tk, {req, " taken"}, taken_o, e_tk);
    chk(next_pc_o == e_pc, {req, e_tk ? " R3 pc" : " R4 pc"}, next_pc_o, e_pc);
    chk(carry_o == e_cy, {req, " R8 carry"}, carry_o, e_cy);
    chk(loop_o == e_lp, {req, " R9 loop"}, loop_o, e_lp);
    chk(cycles_o == (e_tk ? 2'd2 : 2'd1), "R10 cycles", cycles_o, e_tk ? 2 : 1);
  endtask

  initial begin
    logic [15:0] hold_pc;
    #1;
    chk(done_o == 0 && next_pc_o == 0 && taken_o == 0, "R1 in reset", next_pc_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 0 && next_pc_o == 0 && loop_o == 0 && cycles_o == 0 && carry_o == 0,
        "R1 after reset", {next_pc_o, loop_o}, 0);
    // R3 R5: every displacement, near both ends of the address space
    for (int d = 0; d < 256; d++) begin
      run_op(3'd0, 16'hFFF0, 2'd2, 1'b1, 8'h5, 8'h1, 8'h2, 8'h3, 8'(d), "R5 sjmp hi");
      run_op(3'd0, 16'h0010, 2'd3, 1'b0, 8'h0, 8'h1, 8'h1, 8'h3, 8'(d), "R5 sjmp lo");
    end
    run_op(3'd0, 16'h0100, 2'd2, 1'b0, 8'h0, 8'h0, 8'h0, 8'h0, 8'hFB, "R3 minus five");
    chk(next_pc_o == 16'h00FD, "R3 0xFB is -5", next_pc_o, 16'h00FD);
    // R6 JZ
    for (int v = 0; v < 256; v += 17)
      run_op(3'd1, 16'h2000, 2'd2, v[0], 8'(v), 8'h0, 8'h0, 8'h9, 8'h80, "R6 jz");
    run_op(3'd1, 16'h2000, 2'd2, 1'b1, 8'h00, 8'h0, 8'h0, 8'h9, 8'h7F, "R6 jz zero");
    // R7 JNC
    for (int c = 0; c < 2; c++)
      for (int d = 0; d < 256; d += 51)
        run_op(3'd2, 16'hFFFE, 2'd2, c[0], 8'h0, 8'h0, 8'h0, 8'h4, 8'(d), "R7 jnc");
    // R8 CJNE grid
    for (int a = 0; a < 256; a += 15)
      for (int b = 0; b < 256; b += 15)
        for (int cy = 0; cy < 2; cy++)
          run_op(3'd3, 16'h4000, 2'd3, cy[0], 8'h1, 8'(a), 8'(b), 8'h7, 8'hF0, "R8 cjne");
    run_op(3'd3, 16'h4000, 2'd3, 1'b1, 8'h1, 8'hFF, 8'hFF, 8'h7, 8'h10, "R8 cjne eq");
    // R9 DJNZ every loop value
    for (int l = 0; l < 256; l++)
      run_op(3'd4, 16'h0003, 2'd2, l[1], 8'h0, 8'h0, 8'h0, 8'(l), 8'hFA, "R9 djnz");
    // R11 reserved codes
    for (int c = 5; c < 8; c++) begin
      run_op(3'(c), 16'h1234, 2'd1, 1'b1, 8'h0, 8'h1, 8'h2, 8'h1, 8'h20, "R11 reserved");
      run_op(3'(c), 16'hFFFF, 2'd1, 1'b0, 8'h0, 8'h3, 8'h2, 8'h0, 8'h20, "R11 reserved wrap");
    end
    // R2 hold without start
    hold_pc = next_pc_o;
    pc_i = 16'hAAAA; disp_i = 8'h55; cls_i = 3'd0;
    repeat (3) @(negedge clk_i);
    chk(done_o == 0, "R2 no done", done_o, 0);
    chk(next_pc_o == hold_pc, "R2 hold", next_pc_o, hold_pc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule